// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

A memory-mapped watchdog that counts down from a programmable reload value. Software keeps it from expiring by writing a fixed 16-bit key to a restart register. Writes of any other value to that register do nothing. The count advances either on every clock or only on cycles where an external 1 MHz tick enable is high, as the control register selects. The counter is 32 bits wide, so at 1 MHz the longest interval is about 4295 seconds.

When the count reaches zero the block reloads and keeps counting. On that expiry it can send a one-cycle reset request, a one-cycle external-signal pulse, or both. The reset request is tagged with a reset scope taken from the control register. Expiry also sets a sticky timeout flag. If the alternate-boot bit is set in control, expiry also sets a sticky alternate-boot flag that the boot logic downstream uses.

An optional early-warning interrupt fires when the count steps down onto a threshold held in the upper control bits. All status flags stay set until software writes the clear register. Resetting the system, routing flash chip selects and shaping the external pulse are done outside this block.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the count and reload registers both read RST_RELOAD (default 0x00FF_FFFF), control and status read 0, and all outputs are low.
- R2: A write of 0x4755 to offset 0x08 loads the count from the reload register at the next edge, and this takes priority over a count step. A write of any other value at 0x08 leaves the count to its normal behaviour.
- R3: Control bit 0 enables counting. With it clear the count holds its value. Setting it again resumes from the held count, not from reload.
- R4: With control bit 4 clear the count steps on every clock. With bit 4 set it steps only on clock edges where `tick_i` is high.
- R5: A step taken while the count is 0 is an expiry, and the count reloads. In the next cycle `rst_req_o` is high for exactly one cycle if control bit 1 is set. `ext_sig_o` is likewise high for one cycle if control bit 3 is set. Status bit 0 becomes 1.
- R6: `rst_scope_o` always equals control bits 6:5: 0 is SoC reset, 1 is full-chip reset and 2 is CPU-only reset.
- R7: With control bit 2 set, a step that takes the count onto the value in control bits 31:10 sets status bit 2 and raises `irq_o`. Both stay set until cleared. With bit 2 clear, passing the threshold sets nothing.
- R8: An expiry with control bit 7 set sets status bit 1 and `alt_boot_o`. An expiry with bit 7 clear leaves both unchanged.
- R9: Writing a value with bit 0 set to offset 0x14 clears status bits 2:0 (and the outputs driven by them). A write there with bit 0 clear has no effect.
- R10: Reads return the count at 0x00, reload at 0x04, control at 0x0C and status at 0x10, with 0 read at 0x08 and 0x14. Writes to 0x00 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | 1 MHz tick enable, used when control bit 4 is set |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| rst_req_o | output | 1 | One-cycle reset request on expiry |
| rst_scope_o | output | 2 | Reset scope for the request |
| ext_sig_o | output | 1 | One-cycle external-signal pulse on expiry |
| irq_o | output | 1 | Pretimeout interrupt (sticky) |
| alt_boot_o | output | 1 | Alternate boot source selected (sticky) |

## Verification
A wrong count shows on the count register at once. It is read back after a known number of edges, so an off-by-one in the step, hold or reload path differs by one from the computed value. Bad expiry logic shows one cycle after the edge on which the count is zero: `rst_req_o`, `ext_sig_o` and the status register are sampled exactly there, and again one cycle later to confirm the pulse is one cycle long. A status flag that is set wrongly, or not kept, shows on `irq_o` or `alt_boot_o`. Those are sampled a cycle after the threshold or expiry edge and again several cycles later.

// File: rtl/wdt_pkg.sv
// Shared types and constants for the keyed watchdog.
// Assumes a 32-bit register bus and byte offsets on a small address field.
package wdt_pkg;
    localparam int DATA_W = 32;
    localparam int THR_W  = 22;
    localparam int PAD_W  = DATA_W - THR_W;

    localparam logic [7:0] OFF_COUNT   = 8'h00;
    localparam logic [7:0] OFF_RELOAD  = 8'h04;
    localparam logic [7:0] OFF_RESTART = 8'h08;
    localparam logic [7:0] OFF_CTRL    = 8'h0C;
    localparam logic [7:0] OFF_STATUS  = 8'h10;
    localparam logic [7:0] OFF_CLEAR   = 8'h14;

    localparam logic [15:0] RESTART_KEY = 16'h4755;

    // Control word layout; the threshold sits in the top bits.
    typedef struct packed {
        logic [THR_W-1:0] pre_thr;
        logic [1:0]       spare;
        logic             alt_sel;
        logic [1:0]       scope;
        logic             tick_sel;
        logic             ext_en;
        logic             irq_en;
        logic             rst_en;
        logic             run;
    } ctrl_t;
endpackage

// File: rtl/wdt_regfile.sv
// Register decode: holds reload and control, turns writes into restart and
// clear strobes, and muxes read data. Assumes single-cycle writes on bus_we.
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter logic [DATA_W-1:0] RST_RELOAD = 32'h00FF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] cnt_i,
    input  logic [2:0]        sts_i,
    output logic [DATA_W-1:0] reload_o,
    output logic              run_o,
    output logic              rst_en_o,
    output logic              irq_en_o,
    output logic              ext_en_o,
    output logic              tick_sel_o,
    output logic [1:0]        scope_o,
    output logic              alt_sel_o,
    output logic [THR_W-1:0]  pre_thr_o,
    output logic              restart_o,
    output logic              clr_o
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] reload_q;
    logic              wr_reload, wr_ctrl;

    // Decode write strobes per register.
    always_comb begin
        wr_reload = bus_we && (bus_addr == ADDR_W'(OFF_RELOAD));
        wr_ctrl   = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
        restart_o = bus_we && (bus_addr == ADDR_W'(OFF_RESTART))
                    && (bus_wdata == {{(DATA_W-16){1'b0}}, RESTART_KEY});
        clr_o     = bus_we && (bus_addr == ADDR_W'(OFF_CLEAR)) && bus_wdata[0];
    end

    // Store reload value and control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= RST_RELOAD;
            ctrl_q   <= '0;
        end else begin
            if (wr_reload) reload_q <= bus_wdata;
            if (wr_ctrl)   ctrl_q   <= ctrl_t'(bus_wdata);
        end
    end

    // Read data multiplexer.
    always_comb begin
        case (bus_addr)
            ADDR_W'(OFF_COUNT):  bus_rdata = cnt_i;
            ADDR_W'(OFF_RELOAD): bus_rdata = reload_q;
            ADDR_W'(OFF_CTRL):   bus_rdata = ctrl_q;
            ADDR_W'(OFF_STATUS): bus_rdata = {{(DATA_W-3){1'b0}}, sts_i};
            default:             bus_rdata = '0;
        endcase
    end

    // Break the control word out into named fields.
    always_comb begin
        reload_o   = reload_q;
        run_o      = ctrl_q.run;
        rst_en_o   = ctrl_q.rst_en;
        irq_en_o   = ctrl_q.irq_en;
        ext_en_o   = ctrl_q.ext_en;
        tick_sel_o = ctrl_q.tick_sel;
        scope_o    = ctrl_q.scope;
        alt_sel_o  = ctrl_q.alt_sel;
        pre_thr_o  = ctrl_q.pre_thr;
    end

    AST_RELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == ADDR_W'(OFF_RELOAD)) |=> $stable(reload_o)); // R10
endmodule

// File: rtl/wdt_countdown.sv
// 32-bit down counter with keyed reload, hold, expiry and threshold detection.
// Assumes restart_i is a single-cycle strobe; restart beats a step.
module wdt_countdown
    import wdt_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST_RELOAD = 32'h00FF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              run_i,
    input  logic              tick_sel_i,
    input  logic              restart_i,
    input  logic [DATA_W-1:0] reload_i,
    input  logic [THR_W-1:0]  pre_thr_i,
    output logic [DATA_W-1:0] cnt_o,
    output logic              expire_o,
    output logic              pre_hit_o
);
    logic [DATA_W-1:0] cnt_q, cnt_dec;
    logic              step, at_zero;

    // Work out whether this edge steps, expires or lands on the threshold.
    always_comb begin
        step      = run_i && (!tick_sel_i || tick_i);
        at_zero   = (cnt_q == '0);
        cnt_dec   = cnt_q - 1'b1;
        expire_o  = step && !restart_i && at_zero;
        pre_hit_o = step && !restart_i && !at_zero
                    && (cnt_dec == {{PAD_W{1'b0}}, pre_thr_i});
    end

    // Count register: restart, then step or wrap to reload.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= RST_RELOAD;
        else if (restart_i) cnt_q <= reload_i;
        else if (step)      cnt_q <= at_zero ? reload_i : cnt_dec;
    end

    assign cnt_o = cnt_q;

    AST_KEY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> cnt_q == $past(reload_i)); // R2
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !restart_i) |=> $stable(cnt_q)); // R3
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> cnt_q == $past(reload_i)); // R5
endmodule

// File: rtl/wdt_status.sv
// Sticky status flags and registered expiry pulses.
// Assumes expire_i and pre_hit_i are single-cycle events; a new event beats
// a clear in the same cycle.
module wdt_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire_i,
    input  logic       pre_hit_i,
    input  logic       clr_i,
    input  logic       rst_en_i,
    input  logic       ext_en_i,
    input  logic       irq_en_i,
    input  logic       alt_sel_i,
    output logic [2:0] sts_o,
    output logic       rst_req_o,
    output logic       ext_sig_o
);
    logic [2:0] sts_q;
    logic       rst_req_q, ext_q;

    // Sticky flags: bit0 timeout, bit1 alternate boot, bit2 pretimeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            if (clr_i) sts_q <= '0;
            if (expire_i) begin
                sts_q[0] <= 1'b1;
                if (alt_sel_i) sts_q[1] <= 1'b1;
            end
            if (pre_hit_i && irq_en_i) sts_q[2] <= 1'b1;
        end
    end

    // One-cycle reset request and external pulse after expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
            ext_q     <= 1'b0;
        end else begin
            rst_req_q <= expire_i && rst_en_i;
            ext_q     <= expire_i && ext_en_i;
        end
    end

    assign sts_o     = sts_q;
    assign rst_req_o = rst_req_q;
    assign ext_sig_o = ext_q;

    AST_RST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> $past(rst_en_i)); // R5
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q[2] && !clr_i) |=> sts_q[2]); // R7
    AST_ALT_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts_q[1] && !(expire_i && alt_sel_i)) |=> !sts_q[1]); // R8
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !expire_i && !pre_hit_i) |=> sts_q == 3'b000); // R9
endmodule

// File: rtl/keyed_wdt.sv
// Top of the keyed-restart watchdog: register file, down counter and
// status block. Assumes one clock domain; tick_i is synchronous to clk.
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter logic [31:0] RST_RELOAD = 32'h00FF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              rst_req_o,
    output logic [1:0]        rst_scope_o,
    output logic              ext_sig_o,
    output logic              irq_o,
    output logic              alt_boot_o
);
    logic [DATA_W-1:0] cnt, reload;
    logic [2:0]        sts;
    logic              run, rst_en, irq_en, ext_en, tick_sel, alt_sel;
    logic [1:0]        scope;
    logic [THR_W-1:0]  pre_thr;
    logic              restart, clr, expire, pre_hit;

    wdt_regfile #(.ADDR_W(ADDR_W), .RST_RELOAD(RST_RELOAD)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cnt_i(cnt), .sts_i(sts),
        .reload_o(reload), .run_o(run), .rst_en_o(rst_en), .irq_en_o(irq_en),
        .ext_en_o(ext_en), .tick_sel_o(tick_sel), .scope_o(scope),
        .alt_sel_o(alt_sel), .pre_thr_o(pre_thr),
        .restart_o(restart), .clr_o(clr)
    );

    wdt_countdown #(.RST_RELOAD(RST_RELOAD)) cnt_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .run_i(run), .tick_sel_i(tick_sel), .restart_i(restart),
        .reload_i(reload), .pre_thr_i(pre_thr),
        .cnt_o(cnt), .expire_o(expire), .pre_hit_o(pre_hit)
    );

    wdt_status sts_i (
        .clk(clk), .rst_n(rst_n),
        .expire_i(expire), .pre_hit_i(pre_hit), .clr_i(clr),
        .rst_en_i(rst_en), .ext_en_i(ext_en), .irq_en_i(irq_en),
        .alt_sel_i(alt_sel),
        .sts_o(sts), .rst_req_o(rst_req_o), .ext_sig_o(ext_sig_o)
    );

    // Drive the remaining outputs from control and status.
    always_comb begin
        rst_scope_o = scope;
        irq_o       = sts[2];
        alt_boot_o  = sts[1];
    end

    AST_SCOPE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(rst_scope_o) || $past(bus_we)); // R6
endmodule

// File: tb/keyed_wdt_tb.sv
`timescale 1ns/100ps
module keyed_wdt_tb_top;
    localparam logic [31:0] RST_RL = 32'h00FF_FFFF;

    logic        clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        rst_req_o, ext_sig_o, irq_o, alt_boot_o;
    logic [1:0]  rst_scope_o;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    keyed_wdt #(.ADDR_W(5), .RST_RELOAD(RST_RL)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rst_req_o(rst_req_o), .rst_scope_o(rst_scope_o),
        .ext_sig_o(ext_sig_o), .irq_o(irq_o), .alt_boot_o(alt_boot_o)
    );

    typedef struct packed {
        logic        we;
        logic [4:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    // Register-level vectors, all with counting disabled.
    localparam vec_t VECS [0:10] = '{
        '{1'b1, 5'h04, 32'h0000_0100, 32'h0, 8'd10},   // R10 reload write
        '{1'b0, 5'h04, 32'h0, 32'h0000_0100, 8'd10},   // R10 reload read
        '{1'b1, 5'h00, 32'h0000_1234, 32'h0, 8'd10},   // R10 count write ignored
        '{1'b0, 5'h00, 32'h0, RST_RL, 8'd10},
        '{1'b1, 5'h08, 32'h0000_4754, 32'h0, 8'd2},    // R2 wrong key
        '{1'b0, 5'h00, 32'h0, RST_RL, 8'd2},
        '{1'b1, 5'h08, 32'h0000_4755, 32'h0, 8'd2},    // R2 key
        '{1'b0, 5'h00, 32'h0, 32'h0000_0100, 8'd2},
        '{1'b1, 5'h0C, 32'h0000_0040, 32'h0, 8'd6},    // R6 scope 2
        '{1'b0, 5'h0C, 32'h0, 32'h0000_0040, 8'd10},
        '{1'b0, 5'h08, 32'h0, 32'h0, 8'd10}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Called just after a negedge; returns one negedge later.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not end");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(5'h00, v); chk("R1", "count", v, RST_RL);
        rd(5'h04, v); chk("R1", "reload", v, RST_RL);
        rd(5'h0C, v); chk("R1", "ctrl", v, 32'h0);
        rd(5'h10, v); chk("R1", "status", v, 32'h0);
        chk("R1", "outputs", {28'h0, rst_req_o, ext_sig_o, irq_o, alt_boot_o}, 32'h0);

        // Vector table walk
        for (int i = 0; i <= 10; i++) begin
            if (VECS[i].we) wr(VECS[i].addr, VECS[i].data);
            else begin
                rd(VECS[i].addr, v);
                chk($sformatf("R%0d", VECS[i].req), "table", v, VECS[i].exp);
            end
        end
        chk("R6", "scope cpu", {30'h0, rst_scope_o}, 32'd2);

        // R3 run, hold, resume
        wr(5'h0C, 32'h1);
        idle(10);
        rd(5'h00, v); chk("R3", "counting", v, 32'hF6);
        wr(5'h0C, 32'h0);
        idle(5);
        rd(5'h00, v); chk("R3", "hold", v, 32'hF5);
        wr(5'h0C, 32'h1);
        idle(3);
        rd(5'h00, v); chk("R3", "resume", v, 32'hF2);

        // R4 tick-gated stepping
        wr(5'h0C, 32'h0);
        wr(5'h0C, 32'h11);
        idle(5);
        rd(5'h00, v); chk("R4", "no tick", v, 32'hF1);
        for (int i = 0; i < 3; i++) begin
            tick_i = 1'b1; @(negedge clk); tick_i = 1'b0; @(negedge clk);
        end
        rd(5'h00, v); chk("R4", "three ticks", v, 32'hEE);
        wr(5'h0C, 32'h0);

        // R5 expiry with reset, ext, scope 1 and alternate boot
        wr(5'h04, 32'h3);
        wr(5'h08, 32'h4755);
        wr(5'h0C, 32'hAB);
        idle(3);
        rd(5'h00, v); chk("R5", "at zero", v, 32'h0);
        chk("R5", "no early req", {31'h0, rst_req_o}, 32'h0);
        @(negedge clk);
        chk("R5", "rst_req", {31'h0, rst_req_o}, 32'h1);
        chk("R5", "ext_sig", {31'h0, ext_sig_o}, 32'h1);
        chk("R6", "scope full", {30'h0, rst_scope_o}, 32'd1);
        rd(5'h00, v); chk("R5", "reloaded", v, 32'h3);
        rd(5'h10, v); chk("R8", "status alt", v, 32'h3);
        chk("R8", "alt_boot_o", {31'h0, alt_boot_o}, 32'h1);
        @(negedge clk);
        chk("R5", "pulse width", {30'h0, rst_req_o, ext_sig_o}, 32'h0);
        rd(5'h00, v); chk("R5", "continues", v, 32'h2);
        wr(5'h0C, 32'h0);

        // R9 clear register
        wr(5'h14, 32'h0);
        rd(5'h10, v); chk("R9", "bit0 clear ignored", v, 32'h3);
        wr(5'h14, 32'h1);
        rd(5'h10, v); chk("R9", "cleared", v, 32'h0);
        chk("R9", "alt_boot_o low", {31'h0, alt_boot_o}, 32'h0);

        // R8 expiry without alternate-boot select
        wr(5'h0C, 32'h3);
        idle(2);
        rd(5'h10, v); chk("R8", "no alt flag", v, 32'h1);
        chk("R8", "alt_boot_o", {31'h0, alt_boot_o}, 32'h0);
        chk("R5", "rst_req no ext", {30'h0, rst_req_o, ext_sig_o}, 32'h2);
        wr(5'h0C, 32'h0);
        wr(5'h14, 32'h1);

        // R7 pretimeout at threshold 0x1C
        wr(5'h04, 32'h20);
        wr(5'h08, 32'h4755);
        wr(5'h0C, 32'h7005);
        idle(3);
        chk("R7", "irq before", {31'h0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R7", "irq at thr", {31'h0, irq_o}, 32'h1);
        rd(5'h10, v); chk("R7", "status bit2", v, 32'h4);
        idle(3);
        chk("R7", "irq sticky", {31'h0, irq_o}, 32'h1);
        wr(5'h0C, 32'h0);
        wr(5'h14, 32'h1);
        chk("R9", "irq cleared", {31'h0, irq_o}, 32'h0);

        // R7 disabled interrupt, and R2 keys while running
        wr(5'h08, 32'h4755);
        wr(5'h0C, 32'h7001);
        idle(8);
        rd(5'h00, v); chk("R3", "running", v, 32'h18);
        chk("R7", "irq off", {31'h0, irq_o}, 32'h0);
        wr(5'h08, 32'h4755);
        rd(5'h00, v); chk("R2", "key while running", v, 32'h20);
        wr(5'h08, 32'h1234);
        rd(5'h00, v); chk("R2", "bad key while running", v, 32'h1F);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule